// File: doc/BRIEF.md
# Paged Memory Address Translator

This block turns the 16-bit logical address of an 8-bit CPU into a physical memory address. The logical space is split into eight 8 KB pages. Each page is mapped to a physical 8 KB block through one of two sets of eight page registers, and a task bit chooses the set. A global enable can turn the mapping off, and then each page goes to a fixed block near the top of the first 512 KB. Around the page registers sit three control registers. The mode register holds the mapping enable, the fixed-window enable and the ROM layout mode. The task register picks the page set. The extension register supplies the two block bits above the page register value.

Every access is also sorted into RAM, onboard ROM or cartridge ROM. A block whose low six bits are in the top four codes (0x3C to 0x3F) goes to ROM, unless the all-RAM input is high or the access falls in the fixed window. A four-row table, chosen by the ROM layout mode, turns such a block into a ROM slot. The slot picks either internal or cartridge ROM and one of its four 8 KB segments. Writes that land in ROM are suppressed. The 256-byte window at 0xFE00-0xFEFF can be pinned to RAM block 0x3F whatever the mapping says. The CPU writes the registers through a small synchronous port, and the translation itself is combinational from the register state and the current address.

Top module: `mem_page_translator`

## Requirements
- R1: While reset is held and after it is released, all page and control registers read as zero. With no write since reset, address 0x0000 gives phys_addr 0x70000, with is_rom low.
- R2: A write with reg_we high at a rising edge is visible in the translation from the next cycle. reg_addr 0-7 select set-0 page registers for pages 0-7, 8-15 select set-1 page registers, 16 is the mode register, 17 the task register and 18 the extension register.
- R3: When mode bit 6 is clear, the block is the page number (cpu_addr[15:13]) plus 56. The task and extension registers then have no effect.
- R4: When mode bit 6 is set, the block is {ext[5:4], page_reg[8*task[0] + page]}, a 10-bit number.
- R5: phys_addr (23 bits) is block * 0x2000 + cpu_addr[12:0].
- R6: is_rom is high exactly when block[5:0] >= 0x3C, all_ram is low and the access is not in the pinned window.
- R7: The ROM slot is taken from a table indexed by mode bits 1:0 and by block[5:0]-0x3C. Rows 0 and 1 are {0,1,6,7}, row 2 is {0,1,2,3} and row 3 is {4,5,6,7}.
- R8: When is_rom is high, rom_cart equals slot bit 2 and rom_addr is {slot[1:0], cpu_addr[12:0]}. When is_rom is low, both are zero.
- R9: mem_we equals cpu_wr and not is_rom, so ROM writes never reach memory.
- R10: When mode bit 3 is set and cpu_addr[15:8] is 0xFE, the block is 0x3F and is_rom is low. This holds whatever the mapping enable, the page registers and all_ram say.
- R11: When mode bit 3 is clear, 0xFE00-0xFEFF translates like the rest of page 7.
- R12: Writes to reg_addr 19-31 change no register and leave the translation of every address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 8 | Register write data |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_wr | input | 1 | CPU write access |
| all_ram | input | 1 | All-RAM mode flag; disables ROM redirection |
| phys_addr | output | 23 | Physical RAM address |
| is_rom | output | 1 | Access lands in ROM |
| rom_cart | output | 1 | ROM access targets cartridge ROM |
| rom_addr | output | 15 | Address within the selected ROM |
| mem_we | output | 1 | Write enable passed to memory |

## Verification
The assertions assume that reg_we, reg_addr, reg_wdata, cpu_addr, cpu_wr and all_ram carry known values on every rising edge once the internal reset has been released. They also assume the CPU issues no register write during the two cycles the reset synchroniser needs. The bench changes every input only on the falling clock edge and drives them all to defined values from time zero. It holds reg_we low until the synchronised reset has been released for several cycles, so each write lands where the reference model expects it.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  // Architectural constants shared by the translator submodules.
  localparam int EXT_W      = 2;      // block bits above the page register
  localparam int EXT_LSB    = 4;      // position in the extension register
  localparam int ROMCMP_W   = 6;      // low block bits compared for ROM
  localparam int ROM_FLOOR  = 'h3C;   // first block code redirected to ROM
  localparam int FIX_BLOCK  = 'h3F;   // block used by the pinned window
  localparam int SLOT_W     = 3;      // ROM slot: {cart, segment[1:0]}
  localparam int SEG_W      = 2;

  // Mode register bit positions.
  localparam int MODE_MAP_EN  = 6;
  localparam int MODE_FIX_WIN = 3;

  typedef struct packed {
    logic             map_en;
    logic             fix_win;
    logic [1:0]       rom_mode;
    logic             task_sel;
    logic [EXT_W-1:0] ext_hi;
  } ctl_t;

  // ROM layout table: row = mode, column = block code minus floor.
  function automatic logic [SLOT_W-1:0] rom_slot(input logic [1:0] mode,
                                                 input logic [1:0] col);
    logic [SLOT_W-1:0] s;
    case (mode)
      2'd2:    s = {1'b0, col};
      2'd3:    s = {1'b1, col};
      default: s = col[1] ? {2'b11, col[0]} : {2'b00, col[0]};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int PREG_W = 8,
  parameter int NPREG  = 16,
  parameter int RA_W   = 5,
  localparam int IDX_MODE = NPREG,
  localparam int IDX_TASK = NPREG + 1,
  localparam int IDX_EXT  = NPREG + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [RA_W-1:0]               waddr,
  input  logic [PREG_W-1:0]             wdata,
  output logic [NPREG-1:0][PREG_W-1:0]  page_q,
  output ctl_t                          ctl_q
);

  logic [NPREG-1:0] pg_en;
  logic             mode_en, task_en, ext_en;
  ctl_t             ctl_d;

  // Control register decode and next state.
  always_comb begin
    mode_en = we && (waddr == RA_W'(IDX_MODE));
    task_en = we && (waddr == RA_W'(IDX_TASK));
    ext_en  = we && (waddr == RA_W'(IDX_EXT));
    ctl_d   = ctl_q;
    if (mode_en) begin
      ctl_d.map_en   = wdata[MODE_MAP_EN];
      ctl_d.fix_win  = wdata[MODE_FIX_WIN];
      ctl_d.rom_mode = wdata[1:0];
    end
    if (task_en) ctl_d.task_sel = wdata[0];
    if (ext_en)  ctl_d.ext_hi   = wdata[EXT_LSB +: EXT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctl_q <= '0;
    else if (mode_en || task_en || ext_en) ctl_q <= ctl_d;
  end

  // Page registers, one enable per entry.
  for (genvar g = 0; g < NPREG; g++) begin : g_page
    logic [PREG_W-1:0] d;
    always_comb begin
      pg_en[g] = we && (waddr == RA_W'(g));
      d        = pg_en[g] ? wdata : page_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        page_q[g] <= '0;
      else if (pg_en[g]) page_q[g] <= d;
    end

    p_page_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == RA_W'(g)) |=> (page_q[g] == $past(wdata)));
  end

  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == RA_W'(IDX_MODE)) |=>
      (ctl_q.map_en == $past(wdata[MODE_MAP_EN]) &&
       ctl_q.rom_mode == $past(wdata[1:0])));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || waddr > RA_W'(IDX_EXT)) |=> ($stable(ctl_q) && $stable(page_q)));

endmodule

// File: rtl/pmt_page_map.sv
module pmt_page_map
  import pmt_pkg::*;
#(
  parameter int OFS_W  = 13,
  parameter int PAGE_W = 3,
  parameter int PREG_W = 8,
  localparam int NPAGE = 1 << PAGE_W,
  localparam int NPREG = 2 * NPAGE,
  localparam int VA_W  = PAGE_W + OFS_W,
  localparam int BLK_W = PREG_W + EXT_W,
  localparam int WIN_W = VA_W - 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [VA_W-1:0]               cpu_addr,
  input  logic [NPREG-1:0][PREG_W-1:0]  page_q,
  input  ctl_t                          ctl,
  output logic [BLK_W-1:0]              block,
  output logic                          pinned
);

  localparam logic [WIN_W-1:0] WIN_TAG  = {{(WIN_W-1){1'b1}}, 1'b0};
  localparam int               BYP_BASE = (1 << ROMCMP_W) - NPAGE;

  logic [PAGE_W-1:0]   page;
  logic [PAGE_W:0]     sel_idx;
  logic [PREG_W-1:0]   sel_reg;
  logic [BLK_W-1:0]    mapped_blk, bypass_blk;

  always_comb begin
    page       = cpu_addr[VA_W-1 -: PAGE_W];
    pinned     = ctl.fix_win && (cpu_addr[VA_W-1:8] == WIN_TAG);
    sel_idx    = {ctl.task_sel, page};
    sel_reg    = page_q[sel_idx];
    mapped_blk = {ctl.ext_hi, sel_reg};
    bypass_blk = BLK_W'(BYP_BASE) + BLK_W'(page);
    if (pinned)          block = BLK_W'(FIX_BLOCK);
    else if (ctl.map_en) block = mapped_blk;
    else                 block = bypass_blk;
  end

  p_bypass_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.map_en && !pinned) |-> (block[BLK_W-1:ROMCMP_W] == '0 &&
                                  block[PAGE_W-1:0] == page));

  p_pin_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pinned |-> (block == BLK_W'(FIX_BLOCK)));

endmodule

// File: rtl/pmt_rom_route.sv
module pmt_rom_route
  import pmt_pkg::*;
#(
  parameter int OFS_W = 13,
  parameter int BLK_W = 10,
  localparam int PA_W    = BLK_W + OFS_W,
  localparam int ROM_A_W = SEG_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BLK_W-1:0]   block,
  input  logic [OFS_W-1:0]   offset,
  input  logic               pinned,
  input  logic               all_ram,
  input  logic [1:0]         rom_mode,
  input  logic               cpu_wr,
  output logic [PA_W-1:0]    phys_addr,
  output logic               is_rom,
  output logic               rom_cart,
  output logic [ROM_A_W-1:0] rom_addr,
  output logic               mem_we
);

  logic [ROMCMP_W-1:0] low_code;
  logic                in_rom_zone;
  logic [1:0]          col;
  logic [SLOT_W-1:0]   slot;

  always_comb begin
    low_code    = block[ROMCMP_W-1:0];
    in_rom_zone = (low_code >= ROMCMP_W'(ROM_FLOOR));
    is_rom      = in_rom_zone && !all_ram && !pinned;
    col         = low_code[1:0];
    slot        = rom_slot(rom_mode, col);
    phys_addr   = {block, offset};
    rom_cart    = is_rom && slot[SLOT_W-1];
    rom_addr    = is_rom ? {slot[SEG_W-1:0], offset} : '0;
    mem_we      = cpu_wr && !is_rom;
  end

  p_rom_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rom && cpu_wr) |-> !mem_we);

  p_mode3_cart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rom && rom_mode == 2'd3) |-> rom_cart);

  p_mode2_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_mode == 2'd2) |-> !rom_cart);

endmodule

// File: rtl/mem_page_translator.sv
module mem_page_translator
  import pmt_pkg::*;
#(
  parameter int OFS_W  = 13,
  parameter int PAGE_W = 3,
  parameter int PREG_W = 8,
  parameter int RA_W   = 5,
  localparam int NPAGE   = 1 << PAGE_W,
  localparam int NPREG   = 2 * NPAGE,
  localparam int VA_W    = PAGE_W + OFS_W,
  localparam int BLK_W   = PREG_W + EXT_W,
  localparam int PA_W    = BLK_W + OFS_W,
  localparam int ROM_A_W = SEG_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [PREG_W-1:0]  reg_wdata,
  input  logic [VA_W-1:0]    cpu_addr,
  input  logic               cpu_wr,
  input  logic               all_ram,
  output logic [PA_W-1:0]    phys_addr,
  output logic               is_rom,
  output logic               rom_cart,
  output logic [ROM_A_W-1:0] rom_addr,
  output logic               mem_we
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NPREG-1:0][PREG_W-1:0] page_q;
  ctl_t                         ctl_q;
  logic [BLK_W-1:0]             block;
  logic                         pinned;

  pmt_regs #(.PREG_W(PREG_W), .NPREG(NPREG), .RA_W(RA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (reg_we),
    .waddr  (reg_addr),
    .wdata  (reg_wdata),
    .page_q (page_q),
    .ctl_q  (ctl_q)
  );

  pmt_page_map #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .PREG_W(PREG_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cpu_addr (cpu_addr),
    .page_q   (page_q),
    .ctl      (ctl_q),
    .block    (block),
    .pinned   (pinned)
  );

  pmt_rom_route #(.OFS_W(OFS_W), .BLK_W(BLK_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .block     (block),
    .offset    (cpu_addr[OFS_W-1:0]),
    .pinned    (pinned),
    .all_ram   (all_ram),
    .rom_mode  (ctl_q.rom_mode),
    .cpu_wr    (cpu_wr),
    .phys_addr (phys_addr),
    .is_rom    (is_rom),
    .rom_cart  (rom_cart),
    .rom_addr  (rom_addr),
    .mem_we    (mem_we)
  );

  // Cross-module checks between the map and the router.
  p_pinned_ram_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    pinned |-> !is_rom);

  p_allram_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    all_ram |-> (!is_rom && mem_we == cpu_wr));

  p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_int_n |-> (ctl_q == '0));

endmodule

// File: tb/mem_page_translator_test.sv
module mem_page_translator_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        all_ram = 1'b0;
  logic [22:0] phys_addr;
  logic        is_rom, rom_cart, mem_we;
  logic [14:0] rom_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_page_translator uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .all_ram(all_ram), .phys_addr(phys_addr), .is_rom(is_rom),
    .rom_cart(rom_cart), .rom_addr(rom_addr), .mem_we(mem_we)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference model state.
  int m_pg[16];
  int m_mode = 0, m_task = 0, m_ext = 0;
  int rom_tbl[4][4] = '{'{0,1,6,7}, '{0,1,6,7}, '{0,1,2,3}, '{4,5,6,7}};

  function automatic void model_reset();
    foreach (m_pg[i]) m_pg[i] = 0;
    m_mode = 0; m_task = 0; m_ext = 0;
  endfunction

  function automatic void model_write(int ra, int wd);
    if (ra < 16)       m_pg[ra] = wd;
    else if (ra == 16) m_mode = wd;
    else if (ra == 17) m_task = wd;
    else if (ra == 18) m_ext = wd;
  endfunction

  function automatic void chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (addr 0x%04h)",
               tag, what, act, exp, cpu_addr);
    end
  endfunction

  task automatic compare_now(string tag);
    int a, page, ofs, blk, pin, rom, slot;
    a    = int'(cpu_addr);
    page = a / 8192;
    ofs  = a % 8192;
    pin  = ((a / 256) == 'hFE) && ((m_mode / 8) % 2 == 1);
    if (pin)                     blk = 63;
    else if ((m_mode / 64) % 2)  blk = ((m_ext / 16) % 4) * 256 + m_pg[(m_task % 2) * 8 + page];
    else                         blk = page + 56;
    rom  = !pin && !all_ram && ((blk % 64) >= 60);
    slot = rom ? rom_tbl[m_mode % 4][(blk % 64) - 60] : 0;
    chk(tag, "phys_addr", int'(phys_addr), blk * 8192 + ofs);
    chk(tag, "is_rom",    int'(is_rom),    rom);
    chk(tag, "rom_cart",  int'(rom_cart),  rom ? slot / 4 : 0);
    chk(tag, "rom_addr",  int'(rom_addr),  rom ? (slot % 4) * 8192 + ofs : 0);
    chk(tag, "mem_we",    int'(mem_we),    (cpu_wr && !rom) ? 1 : 0);
  endtask

  // One clock: drive at falling edge, compare, commit model at rising edge.
  task automatic step(string tag, int a, bit wr, bit ar, bit we, int ra, int wd);
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wr = wr; all_ram = ar;
    reg_we = we; reg_addr = 5'(ra); reg_wdata = 8'(wd);
    #1 compare_now(tag);
    @(posedge clk);
    if (we) model_write(ra, wd);
  endtask

  task automatic wr_reg(string tag, int ra, int wd);
    step(tag, 0, 0, 0, 1, ra, wd);
  endtask

  task automatic look(string tag, int a, bit wr, bit ar);
    step(tag, a, wr, ar, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    #1 rst_n = 1'b0;
    // R1: reset state visible while reset is held and after release.
    repeat (3) look("R1", 16'h0000, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) look("R1", 16'h0000, 0, 0);
    look("R1", 16'h1234, 1, 0);

    // R3: bypass mode, every page, with task/ext set that must not matter.
    for (int p = 0; p < 8; p++) look("R3", p * 8192 + 16'h0155, p % 2, 0);
    wr_reg("R3", 17, 1);
    wr_reg("R3", 18, 8'h30);
    for (int p = 0; p < 8; p++) look("R3", p * 8192 + 16'h1ABC, 1, 0);
    for (int p = 0; p < 8; p++) look("R6", p * 8192 + 16'h0042, 1, 1);

    // R2: load both page sets; visible one cycle after the write.
    wr_reg("R2", 17, 0);
    wr_reg("R2", 18, 0);
    for (int i = 0; i < 16; i++) wr_reg("R2", i, (i * 37 + 5) % 256);
    wr_reg("R2", 16, 8'h40);
    look("R2", 16'h2000, 0, 0);

    // R4: set 0 and set 1, with extension bits.
    for (int p = 0; p < 8; p++) look("R4", p * 8192 + 16'h0777, 1, 0);
    wr_reg("R4", 17, 1);
    for (int p = 0; p < 8; p++) look("R4", p * 8192 + 16'h1FFF, 0, 0);
    wr_reg("R4", 18, 8'h20);
    for (int p = 0; p < 8; p++) look("R5", p * 8192, 1, 0);
    wr_reg("R4", 18, 8'hFF);
    look("R5", 16'hFFFF, 1, 0);

    // R6/R7/R8/R9: page registers on ROM codes, every layout mode.
    wr_reg("R7", 17, 0);
    for (int i = 0; i < 8; i++) wr_reg("R7", i, (i % 2) ? 8'h3C + i / 2 : 8'hFC + i / 2);
    for (int md = 0; md < 4; md++) begin
      wr_reg("R7", 16, 8'h40 + md);
      for (int p = 0; p < 8; p++) look("R8", p * 8192 + 16'h0ABC, 1, 0);
      for (int p = 0; p < 8; p++) look("R9", p * 8192 + 16'h0101, 1, 1);
    end
    wr_reg("R6", 0, 8'h3B);
    look("R6", 16'h0010, 1, 0);

    // R10: pinned window, with mapping on, off and all-RAM.
    wr_reg("R10", 16, 8'h48);
    look("R10", 16'hFE00, 1, 0);
    look("R10", 16'hFEFF, 1, 0);
    look("R10", 16'hFF00, 1, 0);
    look("R10", 16'hFDFF, 1, 0);
    wr_reg("R10", 16, 8'h0B);
    look("R10", 16'hFE80, 1, 0);
    look("R10", 16'hFE80, 0, 1);
    look("R10", 16'hE000, 1, 0);

    // R11: window not pinned behaves like page 7.
    wr_reg("R11", 16, 8'h03);
    look("R11", 16'hFE10, 1, 0);
    wr_reg("R11", 16, 8'h42);
    look("R11", 16'hFE10, 1, 0);

    // R12: writes to unused indices leave everything as it was.
    for (int ra = 19; ra < 32; ra++) wr_reg("R12", ra, 8'hFF);
    for (int p = 0; p < 8; p++) look("R12", p * 8192 + 16'h0E00, 1, 0);
    wr_reg("R12", 17, 1);
    for (int ra = 19; ra < 32; ra++) wr_reg("R12", ra, 8'h00);
    for (int p = 0; p < 8; p++) look("R12", p * 8192 + 16'h0E00, 0, 0);

    // R5: mixed random traffic against the model.
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 4) == 0;
      step("R5", int'($urandom % 65536), bit'($urandom % 2), ($urandom % 8) == 0,
           we, int'($urandom % 32), int'($urandom % 256));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule